// File: doc/BRIEF.md
# 16-bit Multi-Cycle Accumulator-Free Processor Core

This block is a small multi-cycle processor core for a 16-bit, word-addressed instruction set. It holds eight general-purpose registers, a program counter and a three-bit one-hot condition register. It steps through fetch, execute and memory states, one memory access per state, over a single-port memory channel. A request is held until the memory answers with a valid strobe.

The instruction set covers conditional branch, add, and, not, direct, base-relative and pointer-indirect loads and stores, load-effective-address, jump, subroutine call with a link register, and trap. The core does not run the trap service routines itself. It raises a service request with the vector and R0, and it waits until an external agent acknowledges and returns a new R0. One trap vector stops the core cleanly. Undefined opcodes and unknown vectors stop it with an error flag.

Top module: `lc3_core`

## Requirements
- R1: While reset is held and right after it, the core requests a fetch from address 0x3000, with `halted` and `error` low and the condition register at zero (bit 1).
- R2: Each fetch increments the PC by one. Every PC-relative offset (branch, load, store, indirect pointer, load-effective-address, relative call) is added to the incremented PC. Load-effective-address (opcode 14, dest 11:9, 9-bit offset) writes that sum without a memory access.
- R3: Add (opcode 1) and and (opcode 5) write the register in bits 11:9 from the register in bits 8:6 and a second operand. When bit 5 is 1, the second operand is bits 4:0 sign-extended. When bit 5 is 0, it is the register in bits 2:0.
- R4: Not (opcode 9) writes the bitwise complement of the register in bits 8:6 into the register in bits 11:9.
- R5: The condition register is always one-hot: bit 2 negative, bit 1 zero, bit 0 positive. Add, and, not, load-effective-address and the three loads set it from the value written. Stores, branches, jumps and traps leave it unchanged.
- R6: A branch (opcode 0) is taken when its mask in bits 11:9 ANDed with the condition register is nonzero. The target is the PC plus the sign-extended offset in bits 8:0.
- R7: A call (opcode 4) writes the PC into R7. With bit 11 set, it jumps by a sign-extended 11-bit offset. Otherwise it jumps to the register in bits 8:6, read before the link is written, so a call through R7 goes to R7's old value. A jump (opcode 12) loads the PC from the register in bits 8:6.
- R8: Load (2) and store (3) use PC plus a 9-bit offset. Base-relative load (6) and store (7) use the register in bits 8:6 plus a sign-extended 6-bit offset. Stores write the register in bits 11:9.
- R9: Indirect load (10) and store (11) first read a pointer word at PC plus the 9-bit offset, then access the address held in that pointer.
- R10: While a memory request waits for its valid strobe, the request, address, write enable and write data stay unchanged.
- R11: A trap (opcode 15) with vector 0x20 to 0x23 in bits 7:0 raises `trap_req` with the vector and R0. No memory request is made until `trap_ack`, which loads R0 from `trap_r0_new`.
- R12: A trap with vector 0x25 raises `halted` for good, and no further memory request is made.
- R13: Opcodes 8 and 13, and any trap vector other than 0x20 to 0x23 and 0x25, raise `error` for good with `halted` low and no further memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with `mem_valid` |
| mem_valid | input | 1 | Access completed this cycle |
| trap_req | output | 1 | Service request pending |
| trap_vec | output | 8 | Requested trap vector |
| trap_r0 | output | 16 | Current R0 value for the service |
| trap_ack | input | 1 | Service done |
| trap_r0_new | input | 16 | New R0 value, taken with `trap_ack` |
| halted | output | 1 | Stopped by the halt vector |
| error | output | 1 | Stopped by an illegal opcode or vector |

## Verification
The condition register never appears at a port, so the hardest thing to check is that each instruction leaves the right flag. Every flag-setting instruction in the stimulus program is followed by three branch-over-store pairs. These pairs leave a code of 4, 2 or 1 in a memory slot, and the bench compares that code with the flag computed from random operands. The memory model answers after a random number of cycles, so loads, stores and the two-read indirect forms often wait with the request held. A call through R7 itself is covered by a directed program that halts only if the old value of R7 was used.

// File: rtl/lc3_core.sv
module lc3_core #(
  parameter logic [15:0] RESET_PC = 16'h3000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        mem_req,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  input  logic        mem_valid,
  output logic        trap_req,
  output logic [7:0]  trap_vec,
  output logic [15:0] trap_r0,
  input  logic        trap_ack,
  input  logic [15:0] trap_r0_new,
  output logic        halted,
  output logic        error
);
  typedef enum logic [2:0] {S_FETCH, S_EXEC, S_PTR, S_MEM, S_TRAP, S_HALT, S_ERR} state_t;

  localparam logic [3:0] OP_BR = 4'd0, OP_ADD = 4'd1, OP_LD = 4'd2, OP_ST = 4'd3;
  localparam logic [3:0] OP_JSR = 4'd4, OP_AND = 4'd5, OP_LDR = 4'd6, OP_STR = 4'd7;
  localparam logic [3:0] OP_NOT = 4'd9, OP_LDI = 4'd10, OP_STI = 4'd11, OP_JMP = 4'd12;
  localparam logic [3:0] OP_LEA = 4'd14, OP_TRAP = 4'd15;

  state_t      state;
  logic [15:0] pc, ir, addr_q;
  logic [2:0]  cc;
  logic [15:0] rf [8];

  logic [3:0]  op;
  logic [2:0]  rd, rs;
  logic [15:0] off6, off9, off11, opnd_b, pc_rel, alu;
  logic        is_load, is_store, fetching;

  assign op     = ir[15:12];
  assign rd     = ir[11:9];
  assign rs     = ir[8:6];
  assign off6   = {{10{ir[5]}}, ir[5:0]};
  assign off9   = {{7{ir[8]}}, ir[8:0]};
  assign off11  = {{5{ir[10]}}, ir[10:0]};
  assign opnd_b = ir[5] ? {{11{ir[4]}}, ir[4:0]} : rf[ir[2:0]];
  assign pc_rel = pc + off9;

  always_comb begin
    case (op)
      OP_ADD:  alu = rf[rs] + opnd_b;
      OP_AND:  alu = rf[rs] & opnd_b;
      OP_NOT:  alu = ~rf[rs];
      default: alu = pc_rel;
    endcase
  end

  function automatic logic [2:0] flags(input logic [15:0] v);
    if (v == 16'd0) return 3'b010;
    return v[15] ? 3'b100 : 3'b001;
  endfunction

  assign is_load  = (op == OP_LD) || (op == OP_LDR) || (op == OP_LDI);
  assign is_store = (op == OP_ST) || (op == OP_STR) || (op == OP_STI);
  assign fetching = (state == S_FETCH);

  assign mem_req   = fetching || (state == S_PTR) || (state == S_MEM);
  assign mem_addr  = fetching ? pc : addr_q;
  assign mem_we    = (state == S_MEM) && is_store;
  assign mem_wdata = rf[rd];
  assign trap_req  = (state == S_TRAP);
  assign trap_vec  = ir[7:0];
  assign trap_r0   = rf[0];
  assign halted    = (state == S_HALT);
  assign error     = (state == S_ERR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_FETCH;
      pc     <= RESET_PC;
      ir     <= '0;
      addr_q <= '0;
      cc     <= 3'b010;
      for (int i = 0; i < 8; i++) rf[i] <= '0;
    end else begin
      case (state)
        S_FETCH: if (mem_valid) begin
          ir    <= mem_rdata;
          pc    <= pc + 16'd1;
          state <= S_EXEC;
        end
        S_EXEC: begin
          state <= S_FETCH;
          case (op)
            OP_BR: if (|(rd & cc)) pc <= pc_rel;
            OP_ADD, OP_AND, OP_NOT, OP_LEA: begin
              rf[rd] <= alu;
              cc     <= flags(alu);
            end
            OP_LD, OP_ST: begin
              addr_q <= pc_rel;
              state  <= S_MEM;
            end
            OP_LDR, OP_STR: begin
              addr_q <= rf[rs] + off6;
              state  <= S_MEM;
            end
            OP_LDI, OP_STI: begin
              addr_q <= pc_rel;
              state  <= S_PTR;
            end
            OP_JSR: begin
              rf[7] <= pc;
              pc    <= ir[11] ? pc + off11 : rf[rs];
            end
            OP_JMP: pc <= rf[rs];
            OP_TRAP: begin
              if (ir[7:0] == 8'h25)         state <= S_HALT;
              else if (ir[7:2] == 6'b001000) state <= S_TRAP;
              else                           state <= S_ERR;
            end
            default: state <= S_ERR;
          endcase
        end
        S_PTR: if (mem_valid) begin
          addr_q <= mem_rdata;
          state  <= S_MEM;
        end
        S_MEM: if (mem_valid) begin
          if (is_load) begin
            rf[rd] <= mem_rdata;
            cc     <= flags(mem_rdata);
          end
          state <= S_FETCH;
        end
        S_TRAP: if (trap_ack) begin
          rf[0] <= trap_r0_new;
          state <= S_FETCH;
        end
        default: state <= state;
      endcase
    end
  end
endmodule

// File: rtl/lc3_core_chk.sv
module lc3_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_valid,
  input logic [15:0] mem_addr,
  input logic [15:0] mem_wdata,
  input logic        trap_req,
  input logic        trap_ack,
  input logic [7:0]  trap_vec,
  input logic        halted,
  input logic        error,
  input logic [2:0]  cc,
  input logic [15:0] pc,
  input logic        in_fetch
);
  assert_cc_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cc) == 1);

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_fetch && mem_valid |=> pc == $past(pc) + 16'd1);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_valid |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  assert_trap_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && !trap_ack |=> trap_req && $stable(trap_vec));

  assert_trap_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> !mem_req);

  assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && !mem_req);

  assert_err_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    error |=> error && !mem_req && !halted);
endmodule

bind lc3_core lc3_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_valid(mem_valid),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .trap_req(trap_req), .trap_ack(trap_ack),
  .trap_vec(trap_vec), .halted(halted), .error(error), .cc(cc), .pc(pc), .in_fetch(fetching)
);

// File: tb/test_lc3_core.sv
module test_lc3_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req, mem_we, mem_valid;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        trap_req, trap_ack, halted, error;
  logic [7:0]  trap_vec;
  logic [15:0] trap_r0, trap_r0_new;

  lc3_core i_lc3_core (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_valid(mem_valid),
    .trap_req(trap_req), .trap_vec(trap_vec), .trap_r0(trap_r0), .trap_ack(trap_ack),
    .trap_r0_new(trap_r0_new), .halted(halted), .error(error)
  );

  always #10 clk = ~clk;

  localparam logic [15:0] D  = 16'h3080;
  localparam logic [15:0] RS = D + 16'h08;
  localparam logic [15:0] CS = D + 16'h20;
  localparam logic [15:0] Q  = D + 16'h40;

  logic [15:0] mem [0:4095];
  logic [15:0] pa;
  int tests = 0, fails = 0, hs_bad = 0, quiet_bad = 0;
  logic [15:0] trap_new, seen_r0, prev_addr;
  logic [7:0]  seen_vec;
  logic        prev_wait = 1'b0, prev_we = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) mem_valid <= 1'b0;
    else if (mem_valid) mem_valid <= 1'b0;
    else if (mem_req && ($urandom % 3 != 0)) begin
      mem_valid <= 1'b1;
      mem_rdata <= mem[mem_addr[11:0]];
      if (mem_we) mem[mem_addr[11:0]] = mem_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && prev_wait && (!mem_req || mem_addr !== prev_addr || mem_we !== prev_we)) hs_bad++;
    prev_wait = rst_n && mem_req && !mem_valid;
    prev_addr = mem_addr;
    prev_we   = mem_we;
  end

  initial begin
    trap_ack = 1'b0;
    trap_r0_new = '0;
    forever begin
      @(negedge clk);
      if (trap_req && !trap_ack) begin
        seen_vec = trap_vec;
        seen_r0  = trap_r0;
        repeat (3) begin
          @(negedge clk);
          if (mem_req || !trap_req) quiet_bad++;
        end
        trap_r0_new = trap_new;
        trap_ack = 1'b1;
        @(negedge clk);
        trap_ack = 1'b0;
      end
    end
  end

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] flag3(input logic [15:0] v);
    if (v == 16'd0) return 16'd2;
    return v[15] ? 16'd4 : 16'd1;
  endfunction

  function automatic logic [15:0] sx5(input logic [4:0] v);
    return {{11{v[4]}}, v};
  endfunction

  function automatic logic [15:0] pcr(input logic [3:0] op, input logic [2:0] r, input logic [15:0] tgt);
    logic [15:0] d;
    d = tgt - pa - 16'd1;
    return {op, r, d[8:0]};
  endfunction

  task automatic put(input logic [15:0] w);
    mem[pa[11:0]] = w;
    pa = pa + 16'd1;
  endtask

  task automatic poke(input logic [15:0] a, input logic [15:0] v);
    mem[a[11:0]] = v;
  endtask

  task automatic clear();
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    pa = 16'h3000;
  endtask

  task automatic blk(input logic [15:0] w, input int i);
    put(w);
    put(pcr(4'h3, 3'd3, RS + 16'(i)));
    put(16'h0601); put(pcr(4'h3, 3'd4, CS + 16'(i)));
    put(16'h0A01); put(pcr(4'h3, 3'd5, CS + 16'(i)));
    put(16'h0C01); put(pcr(4'h3, 3'd6, CS + 16'(i)));
  endtask

  task automatic run();
    int n;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset fetch address", mem_addr, 16'h3000);
    check("R1 reset request", {15'd0, mem_req}, 16'd1);
    check("R1 reset stop flags", {14'd0, halted, error}, 16'd0);
    rst_n = 1'b1;
    n = 0;
    while (!(halted || error) && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic quiet_after_stop(input string tag);
    int reqs = 0;
    repeat (8) begin
      @(negedge clk);
      if (mem_req) reqs++;
    end
    check(tag, 16'(reqs), 16'd0);
  endtask

  task automatic main_run(input logic [15:0] a, input logic [15:0] b, input logic [4:0] imm,
                          input logic [2:0] mask, input logic [15:0] tnew);
    logic [15:0] jsr_at;
    clear();
    trap_new = tnew;
    seen_vec = '0;
    seen_r0  = '0;
    poke(D, a); poke(D + 1, b); poke(D + 2, 16'd4); poke(D + 3, 16'd2); poke(D + 4, 16'd1);
    poke(D + 5, Q);
    put(pcr(4'h2, 3'd1, D)); put(pcr(4'h2, 3'd2, D + 1));
    put(pcr(4'h2, 3'd4, D + 2)); put(pcr(4'h2, 3'd5, D + 3)); put(pcr(4'h2, 3'd6, D + 4));
    blk({4'h1, 3'd3, 3'd1, 3'b000, 3'd2}, 0);
    blk({4'h5, 3'd3, 3'd1, 3'b000, 3'd2}, 1);
    blk({4'h1, 3'd3, 3'd1, 1'b1, imm}, 2);
    blk({4'h5, 3'd3, 3'd1, 1'b1, imm}, 3);
    blk({4'h9, 3'd3, 3'd1, 6'h3F}, 4);
    blk(pcr(4'h2, 3'd3, D), 5);
    blk(pcr(4'hE, 3'd3, D), 6);
    put(pcr(4'hE, 3'd2, D));
    blk({4'h6, 3'd3, 3'd2, 6'd1}, 7);
    put({4'h7, 3'd1, 3'd2, 6'd31});
    put(pcr(4'hB, 3'd1, D + 5));
    blk(pcr(4'hA, 3'd3, D + 5), 8);
    put(pcr(4'h2, 3'd3, D));
    put({4'h0, mask, 9'd1});
    put(pcr(4'h3, 3'd6, D + 16'h18));
    jsr_at = pa;
    put({4'h4, 1'b1, 11'd1});
    put({4'h0, 3'b111, 9'd2});
    put(pcr(4'h3, 3'd7, D + 16'h19));
    put({4'hC, 3'd0, 3'd7, 6'd0});
    put(pcr(4'h2, 3'd0, D + 1));
    put(16'hF021);
    put(pcr(4'h3, 3'd0, D + 16'h1A));
    put(16'hF025);
    run();
    check("R12 halted after halt vector", {14'd0, halted, error}, 16'd2);
    quiet_after_stop("R12 no request after halt");
    check("R3 add register",      mem[RS[11:0] + 0], a + b);
    check("R5 flags add register", mem[CS[11:0] + 0], flag3(a + b));
    check("R3 and register",      mem[RS[11:0] + 1], a & b);
    check("R5 flags and register", mem[CS[11:0] + 1], flag3(a & b));
    check("R3 add immediate",     mem[RS[11:0] + 2], a + sx5(imm));
    check("R5 flags add immediate", mem[CS[11:0] + 2], flag3(a + sx5(imm)));
    check("R3 and immediate",     mem[RS[11:0] + 3], a & sx5(imm));
    check("R5 flags and immediate", mem[CS[11:0] + 3], flag3(a & sx5(imm)));
    check("R4 not",               mem[RS[11:0] + 4], ~a);
    check("R5 flags not",         mem[CS[11:0] + 4], flag3(~a));
    check("R8 load direct",       mem[RS[11:0] + 5], a);
    check("R5 flags load",        mem[CS[11:0] + 5], flag3(a));
    check("R2 load effective address", mem[RS[11:0] + 6], D);
    check("R5 flags lea",         mem[CS[11:0] + 6], 16'd1);
    check("R8 load base-relative", mem[RS[11:0] + 7], b);
    check("R5 flags ldr",         mem[CS[11:0] + 7], flag3(b));
    check("R9 load indirect",     mem[RS[11:0] + 8], a);
    check("R8 store base-relative", mem[D[11:0] + 31], a);
    check("R9 store indirect",    mem[Q[11:0]], a);
    check("R6 branch mask",       mem[D[11:0] + 16'h18], (|(mask & flag3(a)[2:0])) ? 16'd0 : 16'd1);
    check("R7 call link",         mem[D[11:0] + 16'h19], jsr_at + 16'd1);
    check("R11 trap vector",      {8'd0, seen_vec}, 16'h0021);
    check("R11 trap R0 out",      seen_r0, b);
    check("R11 trap R0 back",     mem[D[11:0] + 16'h1A], tnew);
  endtask

  task automatic err_run(input logic [15:0] w, input string tag);
    clear();
    put(w);
    run();
    check(tag, {14'd0, halted, error}, 16'd1);
    quiet_after_stop("R13 no request after error");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    main_run(16'h7FFF, 16'h0001, 5'h1F, 3'b100, 16'h1234);
    main_run(16'h0000, 16'h0000, 5'h00, 3'b010, 16'h0000);
    main_run(16'hFFFF, 16'h0001, 5'h10, 3'b001, 16'hBEEF);
    for (int k = 0; k < 5; k++)
      main_run(16'($urandom), 16'($urandom), 5'($urandom), 3'($urandom), 16'($urandom));
    clear();
    put(pcr(4'hE, 3'd7, 16'h3004));
    put({4'h4, 1'b0, 2'b00, 3'd7, 6'd0});
    put(16'hF030);
    put(16'hF030);
    put(16'hF025);
    run();
    check("R7 call through R7 uses old value", {14'd0, halted, error}, 16'd2);
    err_run(16'h8000, "R13 opcode 8 error");
    err_run(16'hD000, "R13 opcode 13 error");
    err_run(16'hF030, "R13 unknown vector 0x30");
    err_run(16'hF024, "R13 unknown vector 0x24");
    check("R10 request held while waiting", 16'(hs_bad), 16'd0);
    check("R11 stalled during service", 16'(quiet_bad), 16'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule